// File: doc/BRIEF.md
# CAN Transmit Priority Scheduler

This block decides which pending outgoing message is handed to the CAN protocol engine next. It serves two kinds of requester. The first is a bank of FIFOs, each of which can be set up as transmit or receive; they compete on a programmable 5-bit priority. The second is a single transmit queue with several slots; inside the queue, the pending slot with the numerically lowest identifier goes first. The queue as a whole carries its own 5-bit priority, which is compared against the best FIFO.

Once a source is chosen, the block raises a one-cycle start strobe and holds the selection until the engine reports an outcome: success, lost arbitration or a bus error. A failed attempt is retried on the same source under one of three retry policies: unlimited retries, a limit of three attempts, or a single attempt. A request that runs out of attempts is dropped. Per-source one-cycle pulses report completion or exhaustion, so the requester can clear its request. Message storage, the bit-level protocol and register access sit outside this block.

Top module: `can_tx_sched`

## Requirements
- R1: Only FIFOs whose `fifo_is_tx` bit is 1 and whose `fifo_req` bit is 1 can be selected. A requesting FIFO that is not set up as transmit never produces a start strobe.
- R2: Among eligible FIFOs, the one with the largest 5-bit priority wins. On equal priority, the lower FIFO index wins. FIFO i is reported as `tx_src` = i+1.
- R3: Within the queue, the pending slot with the smallest identifier wins, whatever the slot order. On equal identifiers, the lower slot wins. The slot is reported on `tx_slot`.
- R4: The queue is reported as `tx_src` = 0. It is chosen when its `q_prio` is greater than or equal to the best eligible FIFO priority.
- R5: `tx_start` is a one-cycle strobe. When the block is idle and a candidate exists at a clock edge, the strobe appears after that edge. After a success, a still-pending request is strobed one clock after the cycle that carried the outcome.
- R6: From the strobe until an outcome pulse, `tx_src` and `tx_slot` stay stable and no further strobe is issued, even if a higher-priority request arrives.
- R7: A `tx_ok` pulse during a frame produces a one-cycle pulse on the done bit of that source (`fifo_done[i]` or `q_done[slot]`) after the next edge.
- R8: With `retry_mode` = 1 (three attempts), the first and second failures (`tx_lost` or `tx_err`) do not set any exhausted flag. The third failure pulses the exhausted bit of that source and drops the request.
- R9: With `retry_mode` = 2 or 3 (single attempt), the first failure pulses the exhausted bit of that source.
- R10: With `retry_mode` = 0 (unlimited), no number of failures sets an exhausted flag, and a later success still reports done.
- R11: After a failure that leaves attempts remaining, the same source is strobed again one clock later, ahead of any other request.
- R12: Outcome pulses that arrive while no frame is in progress are ignored: no done or exhausted pulse, and no strobe.
- R13: After reset, `tx_start` and every done and exhausted flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retry_mode | input | 2 | 0 unlimited, 1 three attempts, 2 or 3 single attempt |
| fifo_is_tx | input | NUM_FIFO | FIFO is set up as transmit |
| fifo_req | input | NUM_FIFO | FIFO has a message pending |
| fifo_prio | input | NUM_FIFO*PRIO_W | Priority of each FIFO, FIFO i at bits i*PRIO_W |
| q_req | input | QDEPTH | Queue slot has a message pending |
| q_id | input | QDEPTH*ID_W | Identifier of each queue slot, slot s at bits s*ID_W |
| q_prio | input | PRIO_W | Priority of the queue against the FIFOs |
| tx_ok | input | 1 | Engine reports a successful transmission |
| tx_lost | input | 1 | Engine reports lost arbitration |
| tx_err | input | 1 | Engine reports an error on the bus |
| tx_start | output | 1 | One-cycle start-transmit strobe |
| tx_src | output | SRC_W | Selected source: 0 queue, i+1 FIFO i |
| tx_slot | output | SLOT_W | Selected queue slot when tx_src is 0 |
| fifo_done | output | NUM_FIFO | One-cycle success pulse per FIFO |
| fifo_exhausted | output | NUM_FIFO | One-cycle attempts-exhausted pulse per FIFO |
| q_done | output | QDEPTH | One-cycle success pulse per queue slot |
| q_exhausted | output | QDEPTH | One-cycle attempts-exhausted pulse per queue slot |

## Verification
The hardest state to reach is the third failure under the three-attempt policy while a higher-priority request is also waiting. The counter must have advanced exactly twice on one locked source, and the newcomer must not steal the retries. The bench gets there with a directed sequence. It starts a low-priority FIFO and injects alternating error and lost-arbitration pulses on successive strobes. A higher-priority FIFO is raised after the first failure. The bench then checks that this FIFO is strobed only after the exhaustion pulse.

// File: rtl/can_tx_sched_pkg.sv
package can_tx_sched_pkg;
    typedef enum logic [1:0] {
        RETRY_FOREVER = 2'd0,
        RETRY_THREE   = 2'd1,
        RETRY_ONCE    = 2'd2,
        RETRY_ONCE_B  = 2'd3
    } retry_e;

    localparam int unsigned LIMITED_TRIES = 3;
endpackage

// File: rtl/fifo_prio_pick.sv
module fifo_prio_pick #(
    parameter int N  = 8,
    parameter int PW = 5,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] prio,
    output logic            found,
    output logic [IW-1:0]   idx,
    output logic [PW-1:0]   best
);
    // Strict greater-than keeps the lowest index on equal priority
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio[i*PW +: PW] > best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = prio[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/txq_id_pick.sv
module txq_id_pick #(
    parameter int D  = 4,
    parameter int IDW = 11,
    parameter int SW = (D > 1) ? $clog2(D) : 1
) (
    input  logic [D-1:0]     pend,
    input  logic [D*IDW-1:0] ids,
    output logic             found,
    output logic [SW-1:0]    slot
);
    logic [IDW-1:0] low;

    // Strict less-than keeps the lowest slot on equal identifiers
    always_comb begin
        found = 1'b0;
        slot  = '0;
        low   = '0;
        for (int s = 0; s < D; s++) begin
            if (pend[s] && (!found || ids[s*IDW +: IDW] < low)) begin
                found = 1'b1;
                slot  = SW'(s);
                low   = ids[s*IDW +: IDW];
            end
        end
    end
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
    import can_tx_sched_pkg::*;
#(
    parameter int NUM_FIFO = 8,
    parameter int PRIO_W   = 5,
    parameter int QDEPTH   = 4,
    parameter int ID_W     = 11,
    parameter int SRC_W    = $clog2(NUM_FIFO + 1),
    parameter int SLOT_W   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 retry_mode,
    input  logic [NUM_FIFO-1:0]        fifo_is_tx,
    input  logic [NUM_FIFO-1:0]        fifo_req,
    input  logic [NUM_FIFO*PRIO_W-1:0] fifo_prio,
    input  logic [QDEPTH-1:0]          q_req,
    input  logic [QDEPTH*ID_W-1:0]     q_id,
    input  logic [PRIO_W-1:0]          q_prio,
    input  logic                       tx_ok,
    input  logic                       tx_lost,
    input  logic                       tx_err,
    output logic                       tx_start,
    output logic [SRC_W-1:0]           tx_src,
    output logic [SLOT_W-1:0]          tx_slot,
    output logic [NUM_FIFO-1:0]        fifo_done,
    output logic [NUM_FIFO-1:0]        fifo_exhausted,
    output logic [QDEPTH-1:0]          q_done,
    output logic [QDEPTH-1:0]          q_exhausted
);
    localparam int FI_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1;

    typedef struct packed {
        logic                busy;
        logic                hold;
        logic                start;
        logic [SRC_W-1:0]    src;
        logic [SLOT_W-1:0]   slot;
        logic [1:0]          fails;
        logic [NUM_FIFO-1:0] fdone;
        logic [NUM_FIFO-1:0] fexh;
        logic [QDEPTH-1:0]   qdone;
        logic [QDEPTH-1:0]   qexh;
    } sched_t;

    sched_t s_d, s_q;

    logic              f_found, q_found, pick_q, fail, drop;
    logic [FI_W-1:0]   f_idx;
    logic [PRIO_W-1:0] f_best;
    logic [SLOT_W-1:0] q_slot;
    logic [1:0]        fails_inc;
    retry_e            mode;

    fifo_prio_pick #(.N(NUM_FIFO), .PW(PRIO_W), .IW(FI_W)) u_fpick (
        .cand  (fifo_req & fifo_is_tx),
        .prio  (fifo_prio),
        .found (f_found),
        .idx   (f_idx),
        .best  (f_best)
    );

    txq_id_pick #(.D(QDEPTH), .IDW(ID_W), .SW(SLOT_W)) u_qpick (
        .pend  (q_req),
        .ids   (q_id),
        .found (q_found),
        .slot  (q_slot)
    );

    always_comb begin
        mode      = retry_e'(retry_mode);
        pick_q    = q_found && (!f_found || q_prio >= f_best);
        fail      = tx_lost | tx_err;
        fails_inc = (s_q.fails == 2'd3) ? 2'd3 : s_q.fails + 2'd1;
        case (mode)
            RETRY_FOREVER: drop = 1'b0;
            RETRY_THREE:   drop = (fails_inc == 2'(LIMITED_TRIES));
            default:       drop = 1'b1;
        endcase

        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.fdone = '0;
        s_d.fexh  = '0;
        s_d.qdone = '0;
        s_d.qexh  = '0;

        if (!s_q.busy) begin
            if (s_q.hold) begin
                s_d.start = 1'b1;
                s_d.busy  = 1'b1;
            end else if (pick_q || f_found) begin
                s_d.start = 1'b1;
                s_d.busy  = 1'b1;
                s_d.fails = 2'd0;
                s_d.src   = pick_q ? '0 : SRC_W'(f_idx) + SRC_W'(1);
                s_d.slot  = pick_q ? q_slot : '0;
            end
        end else if (tx_ok || (fail && drop)) begin
            s_d.busy  = 1'b0;
            s_d.hold  = 1'b0;
            s_d.fails = 2'd0;
            for (int i = 0; i < NUM_FIFO; i++) begin
                if (s_q.src == SRC_W'(i + 1)) begin
                    s_d.fdone[i] = tx_ok;
                    s_d.fexh[i]  = !tx_ok;
                end
            end
            for (int s = 0; s < QDEPTH; s++) begin
                if (s_q.src == '0 && s_q.slot == SLOT_W'(s)) begin
                    s_d.qdone[s] = tx_ok;
                    s_d.qexh[s]  = !tx_ok;
                end
            end
        end else if (fail) begin
            s_d.busy  = 1'b0;
            s_d.hold  = 1'b1;
            s_d.fails = fails_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tx_start       = s_q.start;
    assign tx_src         = s_q.src;
    assign tx_slot        = s_q.slot;
    assign fifo_done      = s_q.fdone;
    assign fifo_exhausted = s_q.fexh;
    assign q_done         = s_q.qdone;
    assign q_exhausted    = s_q.qexh;
endmodule

// File: rtl/can_tx_sched_chk.sv
module can_tx_sched_chk #(
    parameter int NUM_FIFO = 8,
    parameter int QDEPTH   = 4,
    parameter int SRC_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          retry_mode,
    input logic                tx_ok,
    input logic                tx_lost,
    input logic                tx_err,
    input logic                tx_start,
    input logic [SRC_W-1:0]    tx_src,
    input logic [NUM_FIFO-1:0] fifo_done,
    input logic [NUM_FIFO-1:0] fifo_exhausted,
    input logic [QDEPTH-1:0]   q_done,
    input logic [QDEPTH-1:0]   q_exhausted
);
    logic in_frame_q, frame_act, outcome;

    assign outcome   = tx_ok | tx_lost | tx_err;
    assign frame_act = in_frame_q | tx_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_frame_q <= 1'b0;
        else        in_frame_q <= frame_act & ~outcome;
    end

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R6
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_act && !outcome) |=> ($stable(tx_src) && !tx_start));

    // R7
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_done, fifo_exhausted, q_done, q_exhausted}));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |=> ({fifo_done, fifo_exhausted, q_done, q_exhausted} == '0));

    // R10
    exhaust_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{fifo_exhausted, q_exhausted}) |-> (retry_mode != 2'd0));
endmodule

bind can_tx_sched can_tx_sched_chk #(
    .NUM_FIFO (NUM_FIFO),
    .QDEPTH   (QDEPTH),
    .SRC_W    (SRC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .retry_mode     (retry_mode),
    .tx_ok          (tx_ok),
    .tx_lost        (tx_lost),
    .tx_err         (tx_err),
    .tx_start       (tx_start),
    .tx_src         (tx_src),
    .fifo_done      (fifo_done),
    .fifo_exhausted (fifo_exhausted),
    .q_done         (q_done),
    .q_exhausted    (q_exhausted)
);

// File: tb/can_tx_sched_bench.sv
`timescale 1ns/1ps
module can_tx_sched_bench;
    localparam int NF = 8;
    localparam int QD = 4;
    localparam int PW = 5;
    localparam int IW = 11;
    localparam int SW = $clog2(NF + 1);
    localparam int LW = $clog2(QD);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      retry_mode = 2'd0;
    logic [NF-1:0]   fifo_is_tx = '0, fifo_req = '0;
    logic [NF*PW-1:0] fifo_prio;
    logic [QD-1:0]   q_req = '0;
    logic [QD*IW-1:0] q_id;
    logic [PW-1:0]   q_prio = '0;
    logic            tx_ok = 1'b0, tx_lost = 1'b0, tx_err = 1'b0;
    logic            tx_start;
    logic [SW-1:0]   tx_src;
    logic [LW-1:0]   tx_slot;
    logic [NF-1:0]   fifo_done, fifo_exhausted;
    logic [QD-1:0]   q_done, q_exhausted;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // FIFO priorities: 3,7,7,1,12,12,0,5 for FIFO 0..7
    assign fifo_prio = {5'd5, 5'd0, 5'd12, 5'd12, 5'd1, 5'd7, 5'd7, 5'd3};
    // Queue identifiers: slot0 0x300, slot1 0x120, slot2 0x7FF, slot3 0x121
    assign q_id = {11'h121, 11'h7FF, 11'h120, 11'h300};

    can_tx_sched #(.NUM_FIFO(NF), .PRIO_W(PW), .QDEPTH(QD), .ID_W(IW)) u_can_tx_sched (
        .clk(clk), .rst_n(rst_n), .retry_mode(retry_mode),
        .fifo_is_tx(fifo_is_tx), .fifo_req(fifo_req), .fifo_prio(fifo_prio),
        .q_req(q_req), .q_id(q_id), .q_prio(q_prio),
        .tx_ok(tx_ok), .tx_lost(tx_lost), .tx_err(tx_err),
        .tx_start(tx_start), .tx_src(tx_src), .tx_slot(tx_slot),
        .fifo_done(fifo_done), .fifo_exhausted(fifo_exhausted),
        .q_done(q_done), .q_exhausted(q_exhausted)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // {req[8], istx[8], qreq[4], qprio[5], exp_src[4] (F = none), exp_slot[2]}
    localparam int NV = 11;
    localparam logic [30:0] VECS [NV] = '{
        {8'h01, 8'hFF, 4'h0, 5'd0,  4'd1, 2'd0},  // R2 single FIFO
        {8'h06, 8'hFF, 4'h0, 5'd0,  4'd2, 2'd0},  // R2 tie -> lower index
        {8'h30, 8'h20, 4'h0, 5'd0,  4'd6, 2'd0},  // R1 FIFO4 not transmit
        {8'hFF, 8'hCF, 4'h0, 5'd0,  4'd2, 2'd0},  // R1 R2 mixed
        {8'h00, 8'hFF, 4'hB, 5'd0,  4'd0, 2'd1},  // R3 lowest id
        {8'h02, 8'hFF, 4'hA, 5'd7,  4'd0, 2'd1},  // R4 tie -> queue
        {8'h02, 8'hFF, 4'h5, 5'd6,  4'd2, 2'd0},  // R4 FIFO higher
        {8'h30, 8'hFF, 4'h5, 5'd12, 4'd0, 2'd0},  // R4 R3 tie at 12
        {8'h80, 8'h7F, 4'h0, 5'd0,  4'hF, 2'd0},  // R1 nothing eligible
        {8'hFF, 8'hFF, 4'hF, 5'd31, 4'd0, 2'd1},  // R4 R3 queue top priority
        {8'h40, 8'hFF, 4'h8, 5'd0,  4'd0, 2'd3}   // R4 tie at zero
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [30:0] v;
        logic [3:0]  es;
        logic [1:0]  el;

        repeat (3) tick();
        check("R13 start in reset", int'(tx_start), 0);
        rst_n = 1'b1;
        tick();
        check("R13 start after reset", int'(tx_start), 0);
        check("R13 flags after reset",
              int'({fifo_done, fifo_exhausted, q_done, q_exhausted}), 0);

        // Table walk: each entry is one successful frame
        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            fifo_req   = v[30:23];
            fifo_is_tx = v[22:15];
            q_req      = v[14:11];
            q_prio     = v[10:6];
            es         = v[5:2];
            el         = v[1:0];
            tick();
            if (es == 4'hF) begin
                check("R1 no strobe", int'(tx_start), 0);
                fifo_req = '0;
                q_req    = '0;
                tick();
            end else begin
                check("R5 strobe", int'(tx_start), 1);
                check("R2 R4 source", int'(tx_src), int'(es));
                if (es == 4'd0) check("R3 slot", int'(tx_slot), int'(el));
                fifo_req = '0;
                q_req    = '0;
                tx_ok    = 1'b1;
                tick();
                tx_ok = 1'b0;
                if (es == 4'd0) check("R7 queue done", int'(q_done), 1 << el);
                else            check("R7 fifo done", int'(fifo_done), 1 << (es - 1));
                check("R5 single strobe", int'(tx_start), 0);
            end
        end
        fifo_is_tx = '1;
        q_prio = '0;

        // R12: outcome pulses while idle
        tx_ok = 1'b1; tx_err = 1'b1; tx_lost = 1'b1;
        tick();
        tx_ok = 1'b0; tx_err = 1'b0; tx_lost = 1'b0;
        tick();
        check("R12 no flags", int'({fifo_done, fifo_exhausted, q_done, q_exhausted}), 0);
        check("R12 no strobe", int'(tx_start), 0);

        // R5 and R6: restart timing and lock
        fifo_req = 8'h02;
        tick();
        check("R5 strobe fifo1", int'(tx_src), 2);
        tx_ok = 1'b1;
        tick();
        tx_ok = 1'b0;
        check("R7 fifo1 done", int'(fifo_done), 8'h02);
        check("R5 gap cycle", int'(tx_start), 0);
        tick();
        check("R5 restrobe one clock later", int'(tx_start), 1);
        fifo_req = 8'h12;
        tick();
        check("R6 no strobe while locked", int'(tx_start), 0);
        tick();
        check("R6 source held", int'(tx_src), 2);
        fifo_req = '0;
        tx_ok = 1'b1;
        tick();
        tx_ok = 1'b0;
        check("R6 done to locked source", int'(fifo_done), 8'h02);
        tick();

        // R8 and R11: three-attempt policy
        retry_mode = 2'd1;
        fifo_req = 8'h04;
        tick();
        check("R11 first strobe", int'(tx_src), 3);
        tx_err = 1'b1;
        tick();
        tx_err = 1'b0;
        check("R8 no exhaust after one", int'(fifo_exhausted), 0);
        fifo_req = 8'h14;
        tick();
        check("R11 retry strobe", int'(tx_start), 1);
        check("R11 retry same source", int'(tx_src), 3);
        tx_lost = 1'b1;
        tick();
        tx_lost = 1'b0;
        check("R8 no exhaust after two", int'(fifo_exhausted), 0);
        tick();
        check("R11 third strobe source", int'(tx_src), 3);
        tx_err = 1'b1;
        tick();
        tx_err = 1'b0;
        check("R8 exhausted after three", int'(fifo_exhausted), 8'h04);
        fifo_req = 8'h10;
        tick();
        check("R8 next source after drop", int'(tx_src), 5);
        fifo_req = '0;
        tx_ok = 1'b1;
        tick();
        tx_ok = 1'b0;
        check("R7 fifo4 done", int'(fifo_done), 8'h10);
        tick();

        // R9: single attempt
        retry_mode = 2'd2;
        fifo_req = 8'h01;
        tick();
        check("R9 strobe", int'(tx_src), 1);
        tx_err = 1'b1;
        fifo_req = '0;
        tick();
        tx_err = 1'b0;
        check("R9 exhausted after one", int'(fifo_exhausted), 8'h01);
        tick();
        check("R9 no retry", int'(tx_start), 0);

        // R10: unlimited retries on a queue slot
        retry_mode = 2'd0;
        q_req = 4'h8;
        tick();
        check("R10 strobe queue slot3", int'(tx_slot), 3);
        for (int f = 0; f < 5; f++) begin
            tx_lost = 1'b1;
            tick();
            tx_lost = 1'b0;
            check("R10 never exhausted", int'(q_exhausted), 0);
            tick();
            check("R10 retry strobe", int'(tx_start), 1);
        end
        q_req = '0;
        tx_ok = 1'b1;
        tick();
        tx_ok = 1'b0;
        check("R10 done after retries", int'(q_done), 4'h8);
        tick();

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule